// File: doc/BRIEF.md
# Receive Byte Queue with Trigger and Character Timeout

This block stores received characters for one serial channel before the host reads them. A receiver shifter writes each finished character, together with its three error flags, into a 16-entry queue. The host reads the oldest entry through a holding-register read strobe. When queueing is switched off, the block keeps a single character instead.

Two requests tell the host when to act. The trigger request rises once the fill level reaches one of four selectable thresholds. The timeout request rises when characters sit below that threshold and no read has happened for four character times. The length of a character time comes from the programmed word format and is measured in half-bit ticks, so a one-and-a-half-bit stop length is counted exactly.

Top module: `uart_rx_queue`

## Requirements
- R1: After a synchronous reset, `empty` is 1 and `level`, `trig_req`, `tmo_req` and `overrun` are all 0.
- R2: Characters leave in the order they arrived. While the queue is not empty, `rd_data` and `rd_err` show the oldest entry. Each entry keeps its 3-bit error flags with it.
- R3: With `fifo_on` = 0 the capacity is one character. A second write with no read in between is dropped and sets `overrun`.
- R4: `trig_sel` picks the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With `fifo_on` = 0 the threshold is 1. `trig_req` is 1 exactly when `level` is at or above the threshold, and it changes on the same edge as `level`.
- R5: A write to a full queue (16 entries, or 1 when queueing is off) with no read is dropped, and `overrun` is set. `overrun` stays set until `lsr_rd` is pulsed. If a drop and `lsr_rd` happen in the same cycle, `overrun` stays set.
- R6: A write and a read in the same cycle carry out both and leave `level` unchanged. On a full queue the write is accepted with no overrun. On an empty queue only the write applies, so `level` becomes 1.
- R7: A read strobe on an empty queue has no effect: `level` stays 0 and `empty` stays 1.
- R8: The timeout period, in half-bit ticks, is 4·(2·(1+N+P)+S). N = 5 + `word_len` is the number of data bits. P = `parity_on`. S is 2 for one stop bit, 3 for `stop_long` with 5 data bits, and 4 for `stop_long` otherwise. `tmo_req` rises on the edge that samples the final tick.
- R9: A `stop_mid` pulse or a read strobe restarts the timeout count, and `tmo_req` falls on that edge.
- R10: `tmo_req` stays 0 while the queue is empty, while the trigger threshold is reached, and while `fifo_on` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Character-complete strobe from the shifter |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags stored with the character |
| stop_mid | input | 1 | Pulse at the centre of each received stop bit |
| rd_en | input | 1 | Host read of the holding register |
| lsr_rd | input | 1 | Host read of line status; clears overrun |
| fifo_on | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| trig_sel | input | 2 | Trigger threshold select |
| word_len | input | 2 | Data bits minus five |
| parity_on | input | 1 | Parity bit present in the frame |
| stop_long | input | 1 | Long stop length (1.5 or 2 bits) |
| half_tick | input | 1 | One pulse per half bit time |
| rd_data | output | 8 | Oldest stored character |
| rd_err | output | 3 | Error flags of the oldest character |
| level | output | 5 | Number of stored characters |
| empty | output | 1 | Queue holds nothing |
| trig_req | output | 1 | Fill level at or above threshold |
| tmo_req | output | 1 | Character timeout pending |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
Several functions can fall in the same cycle. A shifter write can coincide with a host read, and the bench provokes this on an empty queue, on a partly filled queue and on a full queue. It judges each case by the level on the following edge, by the absence of a new overrun, and by the scoreboard order of the bytes read out. A dropped write can also coincide with a line-status read, and the bench checks that `overrun` stays set. Timeout restarts are provoked separately by a stop-bit pulse and by a read, each arriving after the request has risen.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic [2:0] err;
    logic [7:0] data;
  } rxq_entry_t;

  // threshold for each select code
  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // four character times, in half-bit units
  function automatic logic [7:0] tmo_halves(input logic [1:0] wl,
                                            input logic par,
                                            input logic stop2);
    logic [7:0] bits;
    logic [7:0] stop;
    logic [7:0] ch;
    bits = 8'd6 + {6'd0, wl} + {7'd0, par};
    if (!stop2)          stop = 8'd2;
    else if (wl == 2'd0) stop = 8'd3;
    else                 stop = 8'd4;
    ch = (bits << 1) + stop;
    return ch << 2;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  rxq_entry_t      din,
  input  logic            rd_en,
  input  logic            lsr_rd,
  input  logic            cap_one,
  output rxq_entry_t      dout,
  output logic [LW-1:0]   level,
  output logic [LW-1:0]   level_nxt,
  output logic            empty,
  output logic            overrun
);

  rxq_entry_t    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] cap;
  logic          rd_ok, wr_ok, drop;

  assign cap   = cap_one ? LW'(1) : LW'(DEPTH);
  assign rd_ok = rd_en && (level != '0);
  assign wr_ok = wr_en && ((level < cap) || rd_ok);
  assign drop  = wr_en && !wr_ok;

  always_comb begin
    level_nxt = level;
    if (wr_ok && !rd_ok)      level_nxt = level + LW'(1);
    else if (rd_ok && !wr_ok) level_nxt = level - LW'(1);
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= din;
  end

  assign dout = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      level   <= '0;
      empty   <= 1'b1;
      overrun <= 1'b0;
    end else begin
      if (wr_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (rd_ok) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      level <= level_nxt;
      empty <= (level_nxt == '0);
      if (drop)        overrun <= 1'b1;
      else if (lsr_rd) overrun <= 1'b0;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R5
  drop_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && level == LW'(DEPTH)) |=> overrun);

  // R6
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && level != '0 && level <= cap) |=> $stable(level));

  // R7
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && level == '0) |=> (level == '0 && empty));

endmodule

// File: rtl/rxq_trig.sv
module rxq_trig
  import rxq_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_on,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] level_nxt,
  output logic          trig
);

  logic [LW-1:0] thresh;

  assign thresh = fifo_on ? LW'(trig_level(trig_sel)) : LW'(1);

  always_ff @(posedge clk) begin
    if (rst) trig <= 1'b0;
    else     trig <= (level_nxt >= thresh);
  end

  // R4
  trig_match_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(trig_sel) && $stable(fifo_on)) |-> (trig == (level >= thresh)));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
  import rxq_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       hold,
  input  logic       half_tick,
  input  logic [1:0] word_len,
  input  logic       parity_on,
  input  logic       stop_long,
  output logic       expired
);

  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;

  assign limit   = TW'(tmo_halves(word_len, parity_on, stop_long));
  assign expired = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || restart || hold) cnt <= '0;
    else if (half_tick && cnt < limit) cnt <= cnt + TW'(1);
  end

  // R9
  restart_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (restart && !half_tick) |=> !expired);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TW    = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [2:0]    wr_err,
  input  logic          stop_mid,
  input  logic          rd_en,
  input  logic          lsr_rd,
  input  logic          fifo_on,
  input  logic [1:0]    trig_sel,
  input  logic [1:0]    word_len,
  input  logic          parity_on,
  input  logic          stop_long,
  input  logic          half_tick,
  output logic [7:0]    rd_data,
  output logic [2:0]    rd_err,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          trig_req,
  output logic          tmo_req,
  output logic          overrun
);

  rxq_entry_t    din, dout;
  logic [LW-1:0] level_nxt;
  logic          expired;

  assign din = '{err: wr_err, data: wr_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .din(din), .rd_en(rd_en),
    .lsr_rd(lsr_rd), .cap_one(!fifo_on), .dout(dout), .level(level),
    .level_nxt(level_nxt), .empty(empty), .overrun(overrun)
  );

  rxq_trig #(.LW(LW)) u_trig (
    .clk(clk), .rst(rst), .fifo_on(fifo_on), .trig_sel(trig_sel),
    .level(level), .level_nxt(level_nxt), .trig(trig_req)
  );

  rxq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .restart(stop_mid || rd_en), .hold(empty),
    .half_tick(half_tick), .word_len(word_len), .parity_on(parity_on),
    .stop_long(stop_long), .expired(expired)
  );

  assign rd_data = dout.data;
  assign rd_err  = dout.err;
  assign tmo_req = expired && !empty && !trig_req && fifo_on;

  // R10
  tmo_empty_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !tmo_req);

  // R10
  tmo_trig_chk: assert property (@(posedge clk) disable iff (rst)
    trig_req |-> !tmo_req);

endmodule

// File: tb/test_uart_rx_queue.sv
`timescale 1ns/1ps
module test_uart_rx_queue;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, stop_mid = 0, rd_en = 0, lsr_rd = 0, fifo_on = 1;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_err = 0;
  logic [1:0] trig_sel = 0, word_len = 2'd3;
  logic parity_on = 0, stop_long = 0, half_tick = 0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [4:0] level;
  logic empty, trig_req, tmo_req, overrun;

  int checks = 0, errors = 0, mcnt = 0;
  bit done = 0;
  logic [10:0] sb[$];

  always #2.5 clk = ~clk;

  uart_rx_queue i_uart_rx_queue (
    .clk, .rst, .wr_en, .wr_data, .wr_err, .stop_mid, .rd_en, .lsr_rd,
    .fifo_on, .trig_sel, .word_len, .parity_on, .stop_long, .half_tick,
    .rd_data, .rd_err, .level, .empty, .trig_req, .tmo_req, .overrun
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compare each effective read against the scoreboard (R2)
  always @(negedge clk) begin
    if (!rst && rd_en && !empty) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2: actual %0d expected none", {rd_err, rd_data});
      end else begin
        logic [10:0] e;
        e = sb.pop_front();
        if ({rd_err, rd_data} != e) begin
          errors++;
          $display("FAIL R2: actual %0h expected %0h", {rd_err, rd_data}, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; lsr_rd = 0; stop_mid = 0; half_tick = 0;
  endtask

  function automatic int cap();
    return fifo_on ? 16 : 1;
  endfunction

  // driver: one cycle of write and/or read, model updated in step with it
  task automatic cycle(input bit w, input bit r, input logic [7:0] d,
                       input logic [2:0] e, input bit sm);
    bit rok, wok;
    rok = r && mcnt > 0;
    wok = w && (mcnt < cap() || rok);
    if (wok) sb.push_back({e, d});
    mcnt = mcnt + int'(wok) - int'(rok);
    wr_en = w; rd_en = r; wr_data = d; wr_err = e; stop_mid = sm;
    step();
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    cycle(1, 0, d, e, 1);
  endtask

  task automatic pull();
    cycle(0, 1, 8'h00, 3'd0, 0);
  endtask

  task automatic drain();
    while (mcnt > 0) pull();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      half_tick = 1;
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lv [4] = '{1, 4, 8, 14};
    repeat (3) step();
    rst = 0;
    step();
    // R1
    check("R1 empty", empty, 1);
    check("R1 level", level, 0);
    check("R1 trig", trig_req, 0);
    check("R1 tmo", tmo_req, 0);
    check("R1 overrun", overrun, 0);

    // R7: read on empty
    pull();
    check("R7 level", level, 0);
    check("R7 empty", empty, 1);

    // R2/R4: order and threshold 4
    trig_sel = 2'd1;
    push(8'hA1, 3'd1); push(8'hB2, 3'd2); push(8'hC3, 3'd4);
    check("R4 level 3", level, 3);
    check("R4 trig below", trig_req, 0);
    push(8'hD4, 3'd0);
    check("R4 trig at 4", trig_req, 1);
    drain();
    check("R2 empty after drain", empty, 1);

    // R4: every select code
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int k = 0; k < lv[s] - 1; k++) push(8'(k + 16 * s), 3'd0);
      check("R4 below threshold", trig_req, 0);
      push(8'hEE, 3'd3);
      check("R4 at threshold", trig_req, 1);
      drain();
      check("R4 cleared", trig_req, 0);
    end

    // R5: full, drop, sticky, clear, set wins
    for (int k = 0; k < 16; k++) push(8'(k * 7), 3'(k));
    check("R5 full level", level, 16);
    push(8'h55, 3'd0);
    check("R5 dropped level", level, 16);
    check("R5 overrun set", overrun, 1);
    step();
    check("R5 sticky", overrun, 1);
    lsr_rd = 1; step();
    check("R5 cleared", overrun, 0);
    lsr_rd = 1; push(8'h66, 3'd0);
    check("R5 set wins", overrun, 1);
    lsr_rd = 1; step();

    // R6: write and read together when full
    cycle(1, 1, 8'h77, 3'd5, 0);
    check("R6 full both level", level, 16);
    check("R6 full no overrun", overrun, 0);
    drain();
    cycle(1, 1, 8'h88, 3'd6, 0);
    check("R6 empty both level", level, 1);
    push(8'h99, 3'd0); push(8'h9A, 3'd1);
    cycle(1, 1, 8'h9B, 3'd2, 0);
    check("R6 mid both level", level, 3);
    drain();

    // R3: single holding register
    fifo_on = 0;
    push(8'h31, 3'd0);
    check("R3 level one", level, 1);
    check("R4 off threshold", trig_req, 1);
    push(8'h32, 3'd0);
    check("R3 level stays", level, 1);
    check("R3 overrun", overrun, 1);
    lsr_rd = 1; step();
    ticks(120);
    check("R10 off no tmo", tmo_req, 0);
    drain();
    fifo_on = 1;

    // R8: 8 data, no parity, one stop -> 80 half ticks
    trig_sel = 2'd1;
    push(8'h41, 3'd0);
    ticks(79);
    check("R8 8N1 before", tmo_req, 0);
    ticks(1);
    check("R8 8N1 at limit", tmo_req, 1);
    pull();
    check("R9 read clears", tmo_req, 0);

    // R8: 5 data, parity, 1.5 stop -> 68 half ticks
    word_len = 2'd0; parity_on = 1; stop_long = 1;
    push(8'h11, 3'd0); push(8'h12, 3'd0);
    ticks(67);
    check("R8 5P1.5 before", tmo_req, 0);
    ticks(1);
    check("R8 5P1.5 at limit", tmo_req, 1);
    stop_mid = 1; step();
    check("R9 stop clears", tmo_req, 0);
    pull();
    ticks(68);
    check("R9 rearmed", tmo_req, 1);
    pull();
    ticks(100);
    check("R10 empty no tmo", tmo_req, 0);

    // R8: 6 data, no parity, 2 stop -> 4*(14+4)=72
    word_len = 2'd1; parity_on = 0;
    push(8'h21, 3'd0);
    ticks(71);
    check("R8 6N2 before", tmo_req, 0);
    ticks(1);
    check("R8 6N2 at limit", tmo_req, 1);
    drain();

    // R10: threshold reached
    trig_sel = 2'd0;
    push(8'h22, 3'd0);
    ticks(100);
    check("R10 trig no tmo", tmo_req, 0);
    drain();

    step(); step();
    check("R2 scoreboard empty", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule